// File: doc/BRIEF.md
# Self-Timed Byte-Write Nonvolatile Memory Controller

This block is a clocked model of a byte-wide nonvolatile memory. Reads and writes work like a static RAM. It holds a 2048 x 8 main store and a separate 32-byte identification store. All pins are sampled on the system clock. A write is started by a low pulse on the write strobe or the chip select while output enable is high. The block captures the address when the pulse begins and the data when it ends. It then runs a clear phase and a program phase on its own counter, with no further help from the host.

While that sequence runs, the block pulls its shared ready line low. A read during this time returns a status word in which bit 7 is the inverse of the bit 7 being written. A host can therefore detect completion either by watching the shared line or by polling any address. The block also guards against stray writes. Writes are blocked while the supply-good flag is low. After that flag rises, a power-up lockout must expire before a write is accepted. A long strobe held while an overdrive flag is set clears the whole main store. A second overdrive flag maps the top 32 addresses onto the identification store.

Top module: `nvbyte_store`

## Requirements
- R1: After reset, every byte of the main store and of the identification store reads 0xFF. After reset, `busy_pull_o` is low and `data_drive_o` is low.
- R2: When the pins sampled on a clock edge show `ce_n_i`=0, `oe_n_i`=0, `we_n_i`=1 and `oe_hv_i`=0, then after that edge `data_drive_o`=1 and `data_o` holds the selected byte. Otherwise `data_drive_o`=0 and `data_o`=0x00.
- R3: A write can be controlled by `we_n_i` or by `ce_n_i`. The address is the one sampled when both strobes first become low together while `oe_n_i`=1. The data is the one sampled when the first of the two strobes returns high.
- R4: A write pulse that arrives while a write cycle is in progress is ignored. It changes no byte and starts no further cycle.
- R5: `busy_pull_o`=1 means the shared ready line is pulled low. Once a write starts, `busy_pull_o` stays at 1 for exactly WR_CYC consecutive cycles. WR_CYC is 40 when LONG_WRITE=0 (the default) and 200 when LONG_WRITE=1. The first half of the cycle is the clear phase and the second half is the program phase.
- R6: A read during a write cycle returns bit 7 as the inverse of the data bit 7 being written, and bits 6..0 as 0. After the cycle ends, a read returns the true stored byte.
- R7: A strobe pulse sampled with `oe_n_i`=0 does not start a write.
- R8: While `pwr_good_i`=0 no write starts. After `pwr_good_i` rises, no write is accepted until LOCK_CYC cycles (default 24) have passed.
- R9: Holding `ce_n_i`=0, `we_n_i`=0 and `oe_hv_i`=1 for at least CLR_CYC cycles (default 48) sets every main-store byte to 0xFF. A shorter hold has no effect. The identification store is not cleared.
- R10: With `a9_hv_i`=1 and address bits 10..5 all ones (0x7E0 to 0x7FF), reads and writes go to identification byte address[4:0] and not to the main store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | 11 | Byte address |
| data_i | input | 8 | Write data |
| ce_n_i | input | 1 | Chip select, active low |
| oe_n_i | input | 1 | Output enable, active low |
| we_n_i | input | 1 | Write strobe, active low |
| oe_hv_i | input | 1 | Output-enable overdrive flag (enables whole-store clear) |
| a9_hv_i | input | 1 | Address overdrive flag (selects identification store) |
| pwr_good_i | input | 1 | Supply-good flag |
| data_o | output | 8 | Read data (0 when not driven) |
| data_drive_o | output | 1 | Data bus drive enable; low means high impedance |
| busy_pull_o | output | 1 | Open-drain ready line pull-down: 1 pulls low, 0 releases |

## Verification
A wrong sequencer state has two visible symptoms. The ready line either stays low longer or shorter than WR_CYC cycles, or a second cycle appears that no valid pulse started. A length error shows on the cycle the line releases. A wrongly latched address or data byte stays hidden behind the polling word until the cycle ends; the first read after release then returns the wrong byte. Lockout or clear-counter errors show as a cycle starting, or not starting, within a few cycles of the pulse, or as store contents that change after a clear hold that was too short.

// File: rtl/nvbyte_pkg.sv
package nvbyte_pkg;

    localparam int NV_ADDR_W = 11;
    localparam int NV_DATA_W = 8;
    localparam int NV_ID_W   = 5;
    localparam int NV_DEPTH  = 1 << NV_ADDR_W;
    localparam int NV_ID_DEPTH = 1 << NV_ID_W;

    typedef enum logic [1:0] {
        WS_IDLE  = 2'd0,
        WS_ARMED = 2'd1,
        WS_CLEAR = 2'd2,
        WS_PROG  = 2'd3
    } wr_state_e;

    typedef struct packed {
        logic                 ce_n;
        logic                 oe_n;
        logic                 we_n;
        logic                 oe_hv;
        logic                 a9_hv;
        logic                 pwr_good;
        logic [NV_ADDR_W-1:0] addr;
        logic [NV_DATA_W-1:0] data;
    } pin_s;

    typedef struct packed {
        logic                 en;
        logic                 id_sel;
        logic [NV_ADDR_W-1:0] addr;
        logic [NV_DATA_W-1:0] data;
    } cell_wr_s;

    function automatic logic in_id_window(input logic [NV_ADDR_W-1:0] a);
        return &a[NV_ADDR_W-1:NV_ID_W];
    endfunction

    function automatic logic [NV_DATA_W-1:0] poll_word(input logic [NV_DATA_W-1:0] d);
        return {~d[NV_DATA_W-1], {(NV_DATA_W-1){1'b0}}};
    endfunction

endpackage

// File: rtl/nvbyte_pin_sync.sv
module nvbyte_pin_sync
    import nvbyte_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  pin_s pins_i,
    output pin_s pins_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pins_q          <= '0;
            pins_q.ce_n     <= 1'b1;
            pins_q.oe_n     <= 1'b1;
            pins_q.we_n     <= 1'b1;
        end else begin
            pins_q <= pins_i;
        end
    end
endmodule

// File: rtl/nvbyte_seq.sv
module nvbyte_seq
    import nvbyte_pkg::*;
#(
    parameter int WR_CYC   = 40,
    parameter int LOCK_CYC = 24,
    parameter int CLR_CYC  = 48
) (
    input  logic     clk,
    input  logic     rst,
    input  pin_s     pins,
    output logic     busy,
    output logic     lock_ok,
    output logic     clear_all,
    output cell_wr_s cell_wr,
    output logic [NV_DATA_W-1:0] lat_data_o
);
    localparam int HALF = WR_CYC / 2;
    localparam int REST = WR_CYC - HALF;
    localparam int CW   = $clog2(WR_CYC + 1);
    localparam int LW   = $clog2(LOCK_CYC + 1);
    localparam int KW   = $clog2(CLR_CYC + 1);
    localparam logic [CW-1:0] HALF_END = CW'(HALF - 1);
    localparam logic [CW-1:0] REST_END = CW'(REST - 1);
    localparam logic [LW-1:0] LOCK_MAX = LW'(LOCK_CYC);
    localparam logic [KW-1:0] CLR_MAX  = KW'(CLR_CYC);
    localparam logic [KW-1:0] CLR_FIRE = KW'(CLR_CYC - 1);

    wr_state_e            state;
    logic [CW-1:0]        cnt;
    logic [LW-1:0]        lock_cnt;
    logic [KW-1:0]        clr_cnt;
    logic                 wr_seen;
    logic [NV_ADDR_W-1:0] lat_addr;
    logic                 lat_id;
    logic [NV_DATA_W-1:0] lat_data;

    logic wr_level, wr_rise, clr_level, end_ok;

    assign wr_level  = ~pins.ce_n & ~pins.we_n & pins.oe_n & ~pins.oe_hv;
    assign wr_rise   = wr_level & ~wr_seen;
    assign lock_ok   = pins.pwr_good & (lock_cnt == LOCK_MAX);
    assign end_ok    = pins.oe_n & ~pins.oe_hv & lock_ok;
    assign clr_level = ~pins.ce_n & ~pins.we_n & pins.oe_hv & lock_ok & (state == WS_IDLE);
    assign clear_all = clr_level & (clr_cnt == CLR_FIRE);
    assign busy      = (state == WS_CLEAR) | (state == WS_PROG);

    always_comb begin
        cell_wr.en     = ((state == WS_CLEAR) & (cnt == HALF_END)) |
                         ((state == WS_PROG)  & (cnt == REST_END));
        cell_wr.id_sel = lat_id;
        cell_wr.addr   = lat_addr;
        cell_wr.data   = (state == WS_CLEAR) ? '1 : lat_data;
    end

    assign lat_data_o = lat_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= WS_IDLE;
            cnt      <= '0;
            lock_cnt <= '0;
            clr_cnt  <= '0;
            wr_seen  <= 1'b0;
            lat_addr <= '0;
            lat_id   <= 1'b0;
            lat_data <= '0;
        end else begin
            wr_seen <= wr_level;

            if (!pins.pwr_good)
                lock_cnt <= '0;
            else if (lock_cnt != LOCK_MAX)
                lock_cnt <= lock_cnt + 1'b1;

            if (!clr_level)
                clr_cnt <= '0;
            else if (clr_cnt != CLR_MAX)
                clr_cnt <= clr_cnt + 1'b1;

            unique case (state)
                WS_IDLE: begin
                    if (wr_rise && lock_ok) begin
                        state    <= WS_ARMED;
                        lat_addr <= pins.addr;
                        lat_id   <= pins.a9_hv & in_id_window(pins.addr);
                    end
                end
                WS_ARMED: begin
                    if (!wr_level) begin
                        if (end_ok) begin
                            state    <= WS_CLEAR;
                            lat_data <= pins.data;
                            cnt      <= '0;
                        end else begin
                            state <= WS_IDLE;
                        end
                    end
                end
                WS_CLEAR: begin
                    if (cnt == HALF_END) begin
                        state <= WS_PROG;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                WS_PROG: begin
                    if (cnt == REST_END) begin
                        state <= WS_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= WS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/nvbyte_array.sv
module nvbyte_array
    import nvbyte_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  cell_wr_s             cell_wr,
    input  logic                 clear_all,
    input  logic [NV_ADDR_W-1:0] rd_addr,
    input  logic                 rd_id,
    output logic [NV_DATA_W-1:0] rd_data
);
    logic [NV_DATA_W-1:0] main_mem [NV_DEPTH];
    logic [NV_DATA_W-1:0] id_mem   [NV_ID_DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NV_DEPTH; i++) main_mem[i] <= '1;
        end else begin
            if (clear_all)
                for (int i = 0; i < NV_DEPTH; i++) main_mem[i] <= '1;
            if (cell_wr.en && !cell_wr.id_sel)
                main_mem[cell_wr.addr] <= cell_wr.data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int j = 0; j < NV_ID_DEPTH; j++) id_mem[j] <= '1;
        end else if (cell_wr.en && cell_wr.id_sel) begin
            id_mem[cell_wr.addr[NV_ID_W-1:0]] <= cell_wr.data;
        end
    end

    assign rd_data = rd_id ? id_mem[rd_addr[NV_ID_W-1:0]] : main_mem[rd_addr];
endmodule

// File: rtl/nvbyte_store.sv
module nvbyte_store
    import nvbyte_pkg::*;
#(
    parameter bit LONG_WRITE  = 1'b0,
    parameter int WR_FAST_CYC = 40,
    parameter int WR_SLOW_CYC = 200,
    parameter int LOCK_CYC    = 24,
    parameter int CLR_CYC     = 48
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NV_ADDR_W-1:0] addr_i,
    input  logic [NV_DATA_W-1:0] data_i,
    input  logic                 ce_n_i,
    input  logic                 oe_n_i,
    input  logic                 we_n_i,
    input  logic                 oe_hv_i,
    input  logic                 a9_hv_i,
    input  logic                 pwr_good_i,
    output logic [NV_DATA_W-1:0] data_o,
    output logic                 data_drive_o,
    output logic                 busy_pull_o
);
    localparam int WR_CYC = LONG_WRITE ? WR_SLOW_CYC : WR_FAST_CYC;

    pin_s                 pins_raw, pins;
    cell_wr_s             cell_wr;
    logic                 busy, lock_ok, clear_all, rd_en, rd_id;
    logic [NV_DATA_W-1:0] rd_data, lat_data;

    always_comb begin
        pins_raw.ce_n     = ce_n_i;
        pins_raw.oe_n     = oe_n_i;
        pins_raw.we_n     = we_n_i;
        pins_raw.oe_hv    = oe_hv_i;
        pins_raw.a9_hv    = a9_hv_i;
        pins_raw.pwr_good = pwr_good_i;
        pins_raw.addr     = addr_i;
        pins_raw.data     = data_i;
    end

    nvbyte_pin_sync u_sync (
        .clk    (clk),
        .rst    (rst),
        .pins_i (pins_raw),
        .pins_q (pins)
    );

    nvbyte_seq #(
        .WR_CYC   (WR_CYC),
        .LOCK_CYC (LOCK_CYC),
        .CLR_CYC  (CLR_CYC)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .pins       (pins),
        .busy       (busy),
        .lock_ok    (lock_ok),
        .clear_all  (clear_all),
        .cell_wr    (cell_wr),
        .lat_data_o (lat_data)
    );

    assign rd_id = pins.a9_hv & in_id_window(pins.addr);

    nvbyte_array u_array (
        .clk       (clk),
        .rst       (rst),
        .cell_wr   (cell_wr),
        .clear_all (clear_all),
        .rd_addr   (pins.addr),
        .rd_id     (rd_id),
        .rd_data   (rd_data)
    );

    assign rd_en        = ~pins.ce_n & ~pins.oe_n & pins.we_n & ~pins.oe_hv;
    assign data_drive_o = rd_en;
    assign data_o       = !rd_en ? '0 : (busy ? poll_word(lat_data) : rd_data);
    assign busy_pull_o  = busy;
endmodule

// File: rtl/nvbyte_store_chk.sv
module nvbyte_store_chk #(
    parameter int WR_CYC = 40
) (
    input logic       clk,
    input logic       rst,
    input logic       ce_n_i,
    input logic       oe_n_i,
    input logic       busy_pull_o,
    input logic       data_drive_o,
    input logic [7:0] data_o,
    input logic       lock_ok,
    input logic       clear_all
);
    logic [15:0] run;

    always_ff @(posedge clk) begin
        if (rst)              run <= '0;
        else if (busy_pull_o) run <= run + 16'd1;
        else                  run <= '0;
    end

    p_busy_len_r5: assert property (@(posedge clk) disable iff (rst)
        (!busy_pull_o && $past(busy_pull_o)) |-> (run == 16'(WR_CYC)));

    p_hiz_r2: assert property (@(posedge clk) disable iff (rst)
        ($past(ce_n_i) || $past(oe_n_i)) |-> (!data_drive_o && data_o == 8'h00));

    p_poll_low_r6: assert property (@(posedge clk) disable iff (rst)
        (busy_pull_o && data_drive_o) |-> (data_o[6:0] == 7'd0));

    p_start_unlocked_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_pull_o) |-> $past(lock_ok));

    p_clear_idle_r9: assert property (@(posedge clk) disable iff (rst)
        clear_all |-> !busy_pull_o);
endmodule

bind nvbyte_store nvbyte_store_chk #(.WR_CYC(WR_CYC)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .ce_n_i       (ce_n_i),
    .oe_n_i       (oe_n_i),
    .busy_pull_o  (busy_pull_o),
    .data_drive_o (data_drive_o),
    .data_o       (data_o),
    .lock_ok      (lock_ok),
    .clear_all    (clear_all)
);

// File: tb/sim_nvbyte_store.sv
module sim_nvbyte_store;
    localparam int WR   = 40;
    localparam int LOCK = 24;
    localparam int CLRC = 48;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [10:0] addr = '0;
    logic [7:0]  din = '0;
    logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic        oe_hv = 1'b0, a9_hv = 1'b0, pwr = 1'b1;
    logic [7:0]  dout;
    logic        drv, busy;

    always #2 clk = ~clk;

    nvbyte_store u0 (
        .clk(clk), .rst(rst), .addr_i(addr), .data_i(din),
        .ce_n_i(ce_n), .oe_n_i(oe_n), .we_n_i(we_n),
        .oe_hv_i(oe_hv), .a9_hv_i(a9_hv), .pwr_good_i(pwr),
        .data_o(dout), .data_drive_o(drv), .busy_pull_o(busy)
    );

    int n_run = 0, n_fail = 0;
    int cyc = 0;
    int run = 0, last_len = 0, starts = 0;
    bit done = 1'b0;

    int         q_due[$];
    logic [8:0] q_exp[$];
    string      q_tag[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // monitor: pops expected read results when they fall due
    always @(negedge clk) begin
        while (q_due.size() > 0 && q_due[0] == cyc) begin
            int         d;
            logic [8:0] e;
            string      t;
            d = q_due.pop_front();
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            check({drv, dout} == e, t, int'({drv, dout}), int'(e));
        end
    end

    // ready-line run tracker
    always @(negedge clk) begin
        if (busy) run++;
        else begin
            if (run > 0) begin
                last_len = run;
                starts++;
            end
            run = 0;
        end
    end

    task automatic rd(input logic [10:0] a, input logic hv, input logic [7:0] exp, input string tag);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = a; a9_hv = hv;
        q_due.push_back(cyc + 1);
        q_exp.push_back({1'b1, exp});
        q_tag.push_back(tag);
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1; a9_hv = 1'b0;
    endtask

    task automatic nodrive(input logic c, input logic o, input logic w, input string tag);
        @(negedge clk);
        ce_n = c; oe_n = o; we_n = w;
        q_due.push_back(cyc + 1);
        q_exp.push_back(9'h000);
        q_tag.push_back(tag);
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    endtask

    task automatic wr(input logic [10:0] a, input logic [7:0] d, input bit ce_ctrl, input logic hv);
        @(negedge clk);
        addr = a; din = d; oe_n = 1'b1; a9_hv = hv;
        if (ce_ctrl) we_n = 1'b0; else ce_n = 1'b0;
        @(negedge clk);
        if (ce_ctrl) ce_n = 1'b0; else we_n = 1'b0;
        repeat (3) @(negedge clk);
        if (ce_ctrl) ce_n = 1'b1; else we_n = 1'b1;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
        @(negedge clk);
        a9_hv = 1'b0;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 400 && busy; k++) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int s0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(busy == 1'b0, "R1 ready line released after reset", busy, 0);
        check(drv == 1'b0, "R1 bus not driven after reset", drv, 0);

        // R8: write during power-up lockout is ignored
        wr(11'h010, 8'h5A, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        check(starts == 0 && !busy, "R8 write during lockout ignored", starts, 0);
        repeat (LOCK + 4) @(negedge clk);
        rd(11'h010, 1'b0, 8'hFF, "R8 lockout write left byte erased");
        rd(11'h000, 1'b0, 8'hFF, "R1 main byte erased after reset");
        rd(11'h7E0, 1'b1, 8'hFF, "R1 id byte erased after reset");

        // R2: bus released when not reading
        nodrive(1'b0, 1'b1, 1'b1, "R2 oe high gives no drive");
        nodrive(1'b1, 1'b0, 1'b1, "R2 ce high gives no drive");

        // R3/R5/R6/R4: strobe-controlled write, polling, ignored write
        s0 = starts;
        wr(11'h123, 8'hA5, 1'b0, 1'b0);
        check(busy == 1'b1, "R5 ready line pulled after write", busy, 1);
        rd(11'h123, 1'b0, 8'h00, "R6 polling word for A5");
        rd(11'h456, 1'b0, 8'h00, "R6 polling word at other address");
        wr(11'h124, 8'h11, 1'b0, 1'b0);
        wait_idle();
        check(last_len == WR, "R5 busy length", last_len, WR);
        check(starts == s0 + 1, "R4 no extra cycle from write while busy", starts, s0 + 1);
        rd(11'h123, 1'b0, 8'hA5, "R3 strobe-controlled write data");
        rd(11'h124, 1'b0, 8'hFF, "R4 write during busy ignored");
        rd(11'h123, 1'b0, 8'hA5, "R6 true data after cycle");

        // R3: chip-select-controlled write
        wr(11'h7FF, 8'h3C, 1'b1, 1'b0);
        rd(11'h7FF, 1'b0, 8'h80, "R6 polling word for 3C");
        wait_idle();
        check(last_len == WR, "R5 busy length select-controlled", last_len, WR);
        rd(11'h7FF, 1'b0, 8'h3C, "R3 select-controlled write data");

        // R7: pulse with oe low does nothing
        s0 = starts;
        @(negedge clk);
        addr = 11'h050; din = 8'h12; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0;
        repeat (4) @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        repeat (4) @(negedge clk);
        check(starts == s0 && !busy, "R7 no cycle with oe low", starts, s0);
        rd(11'h050, 1'b0, 8'hFF, "R7 byte unchanged with oe low");

        // R10: identification store
        wr(11'h7E5, 8'h77, 1'b0, 1'b1);
        wait_idle();
        rd(11'h7E5, 1'b1, 8'h77, "R10 id byte written");
        rd(11'h7E5, 1'b0, 8'hFF, "R10 main byte untouched by id write");
        rd(11'h7FF, 1'b1, 8'hFF, "R10 id byte 31 separate from main");
        rd(11'h7FF, 1'b0, 8'h3C, "R10 main byte 7FF kept");

        // R8: supply drop and relock
        s0 = starts;
        @(negedge clk); pwr = 1'b0;
        repeat (2) @(negedge clk);
        wr(11'h200, 8'h81, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        check(starts == s0 && !busy, "R8 no write while supply low", starts, s0);
        pwr = 1'b1;
        wr(11'h200, 8'h81, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        check(starts == s0 && !busy, "R8 no write during relock", starts, s0);
        rd(11'h200, 1'b0, 8'hFF, "R8 byte unchanged during relock");
        repeat (LOCK + 4) @(negedge clk);
        wr(11'h200, 8'h81, 1'b0, 1'b0);
        wait_idle();
        check(starts == s0 + 1, "R8 write accepted after lockout", starts, s0 + 1);
        rd(11'h200, 1'b0, 8'h81, "R8 written byte after lockout");

        // R9: whole-store clear
        @(negedge clk);
        ce_n = 1'b0; oe_hv = 1'b1; oe_n = 1'b1; we_n = 1'b0;
        repeat (20) @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1; oe_hv = 1'b0;
        repeat (2) @(negedge clk);
        rd(11'h123, 1'b0, 8'hA5, "R9 short hold leaves data");
        s0 = starts;
        @(negedge clk);
        ce_n = 1'b0; oe_hv = 1'b1; we_n = 1'b0;
        repeat (CLRC + 10) @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1; oe_hv = 1'b0;
        repeat (2) @(negedge clk);
        check(starts == s0, "R9 clear starts no write cycle", starts, s0);
        rd(11'h123, 1'b0, 8'hFF, "R9 byte 123 cleared");
        rd(11'h7FF, 1'b0, 8'hFF, "R9 byte 7FF cleared");
        rd(11'h200, 1'b0, 8'hFF, "R9 byte 200 cleared");
        rd(11'h7E5, 1'b1, 8'h77, "R9 id store kept");

        repeat (4) @(negedge clk);
        check(q_due.size() == 0, "R2 all reads compared", q_due.size(), 0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule